// File: doc/BRIEF.md
# Serial Two-Wire Register-Access Slave

This block lets a host on a two-wire serial bus read and write a small 8-bit register map. SCL and SDA are sampled in the system clock domain through synchronizers. The block detects START, repeated START and STOP on the sampled lines. It answers one fixed 7-bit device address and acknowledges each byte it takes. After a write address, the first byte loads an internal register pointer. Every later byte in that transfer goes to the register the pointer selects.

A read is normally started with a repeated START after the pointer byte. It returns the pointed register first. Each time the master acknowledges, the pointer steps and the next register follows. The pointer step never lands on the reserved test location. Writes to locations that cannot be written are still acknowledged but change nothing. SDA is modelled as an open-drain output: the block only ever enables a low driver.

The map holds three kinds of entries:
- read-write control registers at the bottom of the address space;
- a window of read-only status inputs;
- one read-write test register, which can only be reached by loading the pointer with its address.

Top module: `i2c_regmap_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0x70, so 0xE0 selects a write and 0xE1 a read. Any other address is not acknowledged, and every following byte is ignored and left without acknowledge until the next START or STOP.
- R2: The first byte after an acknowledged write address is loaded into the register pointer and is acknowledged.
- R3: Each further byte of a write transfer is acknowledged and stored in the register the pointer selects, and the pointer then steps once. When the pointer selects a read-only or absent location, the byte is acknowledged and nothing changes.
- R4: After a read address, the first byte sent is the register selected by the current pointer. Each master acknowledge steps the pointer and sends the next register, most significant bit first.
- R5: When the master does not acknowledge a read byte, the block releases SDA and stays released until the next START or STOP.
- R6: Control registers sit at 0x00 to 0x03, status inputs at 0x10 and 0x11, and the test register at 0x73. Every other address reads as 0xFF.
- R7: A pointer step from 0x72 goes to 0x74, and a step from 0xFF wraps to 0x00. The test register at 0x73 is written or read only after the pointer has been loaded with 0x73 directly.
- R8: The block changes its SDA drive only while SCL is low. An acknowledge holds SDA low for the whole high phase of the ninth clock.
- R9: While reset is held and right after it, SDA is released and every control register and the test register hold zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, pull SDA low |
| stat_i | input | 16 | Read-only status bytes, byte 0 in bits 7:0 |
| ctrl_q | output | 32 | Control register contents, register 0 in bits 7:0 |
| test_q | output | 8 | Test register contents |

## Verification
The bench uses the default parameters: four control registers, two status bytes at 0x10, the test location at 0x73, and two synchronizer stages. With these values a wrap from 0xFF lands on a writable control register, so the wrap shows up on the ctrl_q port. Both neighbours of the test location are absent. The skip past 0x73 is therefore observed by writing across it and then reading back the test register value that was loaded earlier. Bus half-periods of eight system clocks leave room for the synchronizer delay. Under that timing, every drive change the block makes must fall inside the SCL low phase.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_RX,
    BUS_TX
  } bus_st_e;

  // Step the register pointer, jumping over the reserved hole
  function automatic logic [7:0] ptr_step(input logic [7:0] p, input logic [7:0] hole);
    logic [7:0] n;
    n = p + 8'd1;
    if (n == hole) n = n + 8'd1;
    return n;
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h70,
  parameter logic [7:0] TEST_ADDR = 8'h73
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  bus_st_e    st;
  logic [3:0] cnt;        // SCL rises seen in the current byte slot (0..9)
  logic [7:0] shreg, txsh;
  logic       ptr_phase, rd_mode, mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= BUS_IDLE; cnt <= '0; shreg <= '0; txsh <= '0; ptr <= '0;
      ptr_phase <= 1'b0; rd_mode <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= BUS_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= BUS_IDLE; cnt <= '0; sda_oe <= 1'b0;
      end else if (st != BUS_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
          if (cnt == 4'd8 && st == BUS_TX) begin
            mack <= ~sda_s;
            if (!sda_s) ptr <= ptr_step(ptr, TEST_ADDR);
          end
          if (cnt < 4'd9) cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            unique case (st)
              BUS_ADDR: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= shreg[0];
                end else begin
                  st <= BUS_IDLE;
                end
              end
              BUS_RX: begin
                sda_oe <= 1'b1;
                if (ptr_phase) begin
                  ptr       <= shreg;
                  ptr_phase <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr_step(ptr, TEST_ADDR);
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            unique case (st)
              BUS_ADDR: begin
                if (rd_mode) begin
                  st     <= BUS_TX;
                  txsh   <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  st        <= BUS_RX;
                  sda_oe    <= 1'b0;
                  ptr_phase <= 1'b1;
                end
              end
              BUS_TX: begin
                if (mack) begin
                  txsh   <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  sda_oe <= 1'b0;
                  st     <= BUS_IDLE;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt != 4'd0 && st == BUS_TX) begin
            sda_oe <= ~txsh[6];
            txsh   <= {txsh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
  parameter int         N_CTRL    = 4,
  parameter int         N_STAT    = 2,
  parameter logic [7:0] STAT_BASE = 8'h10,
  parameter logic [7:0] TEST_ADDR = 8'h73,
  localparam int        CW        = N_CTRL * 8,
  localparam int        SW        = N_STAT * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [7:0]    rd_addr,
  input  logic [SW-1:0] stat_i,
  output logic [CW-1:0] ctrl_q,
  output logic [7:0]    test_q,
  output logic [7:0]    rd_data
);
  logic [7:0] ctrl_r [N_CTRL];
  logic [7:0] test_r;
  logic [7:0] rd_n;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst)                                  ctrl_r[g] <= '0;
      else if (wr_en && wr_addr == 8'(g))       ctrl_r[g] <= wr_data;
    end
    assign ctrl_q[g*8 +: 8] = ctrl_r[g];
  end

  always_ff @(posedge clk) begin
    if (rst)                                    test_r <= '0;
    else if (wr_en && wr_addr == TEST_ADDR)     test_r <= wr_data;
  end
  assign test_q = test_r;

  always_comb begin
    rd_n = 8'hFF;
    for (int i = 0; i < N_CTRL; i++)
      if (rd_addr == 8'(i)) rd_n = ctrl_r[i];
    for (int j = 0; j < N_STAT; j++)
      if (rd_addr == 8'(int'(STAT_BASE) + j)) rd_n = stat_i[j*8 +: 8];
    if (rd_addr == TEST_ADDR) rd_n = test_r;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'hFF;
    else     rd_data <= rd_n;
  end
endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h70,
  parameter int         N_CTRL      = 4,
  parameter int         N_STAT      = 2,
  parameter logic [7:0] STAT_BASE   = 8'h10,
  parameter logic [7:0] TEST_ADDR   = 8'h73,
  parameter int         SYNC_STAGES = 2,
  localparam int        CW          = N_CTRL * 8,
  localparam int        SW          = N_STAT * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [SW-1:0] stat_i,
  output logic [CW-1:0] ctrl_q,
  output logic [7:0]    test_q
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, ptr, rd_data;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.DEV_ADDR(DEV_ADDR), .TEST_ADDR(TEST_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  i2cs_regs #(.N_CTRL(N_CTRL), .N_STAT(N_STAT), .STAT_BASE(STAT_BASE),
              .TEST_ADDR(TEST_ADDR)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .stat_i(stat_i), .ctrl_q(ctrl_q), .test_q(test_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic [CW-1:0] ctrl_q,
  input logic [7:0]    test_q
);
  // R9
  reset_release_chk: assert property (@(posedge clk)
    $fell(rst) |-> (!sda_oe && ctrl_q == '0 && test_q == 8'h00));

  // R8
  sda_drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R3
  ctrl_update_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_q) |-> !scl_i);

  // R7
  test_update_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(test_q) |-> !scl_i);
endmodule

bind i2c_regmap_slave i2cs_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .ctrl_q(ctrl_q), .test_q(test_q)
);

// File: tb/sim_i2c_regmap_slave.sv
module sim_i2c_regmap_slave;
  localparam int         NC  = 4;
  localparam int         NS  = 2;
  localparam logic [7:0] STB = 8'h10;
  localparam logic [7:0] TA  = 8'h73;
  localparam int         HP  = 8;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_low = 1'b0;
  logic sda_oe, sda_bus;
  logic [NC*8-1:0] ctrl_q;
  logic [7:0] test_q;
  logic [NS*8-1:0] stat = 16'hC35A;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_ctrl [NC];
  logic [7:0] m_test = 8'h00;
  logic [7:0] mptr = 8'h00;

  assign sda_bus = ~(m_low | sda_oe);
  always #4 clk = ~clk;

  i2c_regmap_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .stat_i(stat), .ctrl_q(ctrl_q), .test_q(test_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] p);
    logic [7:0] n = p + 8'd1;
    if (n == TA) n = n + 8'd1;
    return n;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a < NC) return m_ctrl[a];
    if (a >= STB && a < STB + NS) return stat[(a-STB)*8 +: 8];
    if (a == TA) return m_test;
    return 8'hFF;
  endfunction

  function automatic void mwrite(input logic [7:0] a, input logic [7:0] d);
    if (a < NC) m_ctrl[a] = d;
    else if (a == TA) m_test = d;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (scl) begin
      m_low = 0; wt(HP); m_low = 1; wt(HP); scl = 0; wt(1);
    end else begin
      m_low = 0; wt(HP); scl = 1; wt(HP); m_low = 1; wt(HP); scl = 0; wt(1);
    end
  endtask

  task automatic bus_stop();
    m_low = 1; wt(HP); scl = 1; wt(HP); m_low = 0; wt(HP);
  endtask

  // sends a byte; ack is true when SDA stays low over the whole ninth high phase
  task automatic send_byte(input logic [7:0] b, output bit ack, output bit steady);
    bit a0, a1;
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wt(HP); scl = 1; wt(HP); scl = 0; wt(1);
    end
    m_low = 0; wt(HP); scl = 1; wt(1);
    a0 = ~sda_bus; wt(HP - 2);
    a1 = ~sda_bus; wt(1);
    scl = 0; wt(1);
    ack = a0 & a1;
    steady = (a0 == a1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      wt(HP); scl = 1; wt(HP / 2); b[i] = sda_bus; wt(HP / 2); scl = 0;
    end
    wt(1); m_low = mack; wt(HP); scl = 1; wt(HP); scl = 0; wt(1); m_low = 0;
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string req);
    bit ack, steady;
    send_byte(b, ack, steady);
    chk(ack == exp_ack, req, ack, exp_ack);
    if (exp_ack) chk(steady, "R8", steady, 1);
  endtask

  task automatic do_write(input logic [7:0] p, input int n);
    logic [7:0] d;
    bus_start();
    send_chk(8'hE0, 1, "R1");
    send_chk(p, 1, "R2");
    mptr = p;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_chk(d, 1, "R3");
      mwrite(mptr, d);
      mptr = nxt(mptr);
    end
    bus_stop();
  endtask

  task automatic read_part(input int n);
    logic [7:0] b, e;
    send_chk(8'hE1, 1, "R1");
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k < n - 1);
      e = exp_rd(mptr);
      if (mptr == TA || mptr < NC || (mptr >= STB && mptr < STB + NS))
        chk(b == e, "R4", b, e);
      else
        chk(b == e, "R6", b, e);
      if (k < n - 1) mptr = nxt(mptr);
    end
    wt(HP / 2);
    chk(sda_bus == 1'b1 && sda_oe == 1'b0, "R5", sda_oe, 0);
    bus_stop();
  endtask

  task automatic ptr_read(input logic [7:0] p, input int n);
    bus_start();
    send_chk(8'hE0, 1, "R1");
    send_chk(p, 1, "R2");
    mptr = p;
    bus_start();
    read_part(n);
  endtask

  task automatic plain_read(input int n);
    bus_start();
    read_part(n);
  endtask

  function automatic logic [7:0] pick();
    case ($urandom % 7)
      0: return 8'($urandom % NC);
      1: return STB + 8'($urandom % NS);
      2: return 8'h72;
      3: return TA;
      4: return 8'hFE;
      5: return 8'h70 + 8'($urandom % 6);
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NC; i++) m_ctrl[i] = 8'h00;
    wt(10);
    // R9 reset state
    chk(ctrl_q == '0 && test_q == 8'h00 && sda_oe == 1'b0, "R9", ctrl_q, 0);
    rst = 0;
    wt(4);
    chk(ctrl_q == '0 && sda_oe == 1'b0 && sda_bus == 1'b1, "R9", sda_oe, 0);

    // R3 R4: block write and readback
    do_write(8'h00, 4);
    chk(ctrl_q == {m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]}, "R3", ctrl_q,
        {m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]});
    ptr_read(8'h00, 4);

    // R3 R6: read-only and absent writes are acked and dropped
    do_write(8'h10, 3);
    ptr_read(8'h0F, 4);

    // R7: direct test access, skip over 0x73, wrap
    do_write(TA, 1);
    chk(test_q == m_test, "R7", test_q, m_test);
    do_write(8'h72, 2);
    chk(test_q == m_test, "R7", test_q, m_test);
    ptr_read(TA, 1);
    ptr_read(8'h71, 3);
    do_write(8'hFF, 2);
    chk(ctrl_q[7:0] == m_ctrl[0], "R7", ctrl_q[7:0], m_ctrl[0]);
    ptr_read(8'hFE, 3);

    // R1: wrong address ignored until STOP
    bus_start();
    send_chk(8'hE2, 0, "R1");
    send_chk(8'h00, 0, "R1");
    send_chk(8'h3C, 0, "R1");
    bus_stop();
    chk(ctrl_q[7:0] == m_ctrl[0], "R1", ctrl_q[7:0], m_ctrl[0]);
    bus_start();
    send_chk(8'hE3, 0, "R1");
    bus_stop();

    // R4: read from the pointer left by an earlier transfer
    plain_read(2);

    for (int it = 0; it < 25; it++) begin
      stat = 16'($urandom);
      if ($urandom % 2) do_write(pick(), 1 + int'($urandom % 4));
      if ($urandom % 3 == 0) plain_read(1 + int'($urandom % 4));
      else ptr_read(pick(), 1 + int'($urandom % 4));
    end
    chk(ctrl_q == {m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]}, "R3", ctrl_q,
        {m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]});
    chk(test_q == m_test, "R7", test_q, m_test);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule